// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which physical page frame to evict when a new page must be brought in. It tracks a recently-used flag, a dirty flag and a small skip counter for every frame. A hand pointer moves around the frames in a ring. Memory references name a frame and say whether the access writes. These references mark the frame as recently used and, for writes, as dirty. A completed writeback clears the dirty flag of the frame it names.

A fault request starts a sweep. During a sweep the hand looks at one frame per clock cycle. A recently-used frame loses its flag and is skipped. A frame whose flag is already clear is also skipped, and its counter goes up, until the frame has been skipped `CHANCES` times. After that it becomes the victim. The engine reports the victim with a one-cycle done pulse and a flag that says whether the frame must be written back first. The hand is then left on the next frame.

With `CHANCES` = 1 the engine behaves as the classic second-chance clock. Larger values keep idle pages resident for more revolutions of the hand.

Top module: `clock_replacer`

## Requirements
- R1: After reset: hand = 0, busy = 0, done = 0, and every frame's used flag, dirty flag and counter is 0. With the default CHANCES = 2, the first sweep after reset lasts NUM_FRAMES+1 busy cycles, chooses frame 0, and reports it clean.
- R2: A reference (refValid = 1, frame refFrame) sets that frame's used flag and clears its counter at the next clock edge.
- R3: A reference with refWrite = 1 sets the frame's dirty flag. wbDone clears the dirty flag of wbFrame. When a write and a writeback name the same frame in the same cycle, the write wins and the flag stays set.
- R4: faultReq is sampled only while idle and raises busy at the next edge. While busy, faultReq is ignored. busy falls on the same edge at which done rises.
- R5: Each busy cycle examines the frame under the hand, then moves the hand to (hand+1) mod NUM_FRAMES. An examined frame whose used flag is set has that flag and its counter cleared.
- R6: An examined frame with a clear used flag and counter = CHANCES-1 is the victim. done pulses for exactly one cycle, with victimFrame equal to that frame. The hand moves to the frame after it, and the victim's counter returns to 0.
- R7: If every frame is recently used when the sweep starts, the victim is the frame the hand started on, after CHANCES·NUM_FRAMES+1 busy cycles.
- R8: An examined frame with a clear used flag whose counter is below CHANCES-1 is skipped, and its counter is incremented.
- R9: victimDirty is the victim's dirty flag at selection time. A write to the victim in the selection cycle counts as dirty.
- R10: If a reference hits the frame under the hand in the same cycle the sweep would clear its used flag, the flag stays set and the counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A frame is referenced this cycle |
| refFrame | input | log2(NUM_FRAMES) | Referenced frame index |
| refWrite | input | 1 | Reference is a write |
| wbDone | input | 1 | Writeback of wbFrame finished |
| wbFrame | input | log2(NUM_FRAMES) | Frame whose writeback finished |
| faultReq | input | 1 | Request a victim |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse: victim is valid |
| victimFrame | output | log2(NUM_FRAMES) | Chosen frame |
| victimDirty | output | 1 | Victim needs writeback before reuse |
| hand | output | log2(NUM_FRAMES) | Current hand position |

## Verification
A reference can land on the frame the hand is examining in the same cycle. In that cycle the sweep wants to clear the used flag and the reference wants to set it. A write and a writeback completion can also target the same frame in one cycle.

The bench provokes both collisions in directed sequences. In the first, it references the starting frame during the first sweep cycle; the victim should then move one frame on. In the second, it issues a write and a writeback to the same frame together; that frame should later come out as a dirty victim. Long random runs make the same collisions occur freely. A cycle-level model in the bench judges every done pulse, victim index, dirty flag and hand position.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;
  typedef enum logic {ST_IDLE, ST_SWEEP} sweepState_t;

  typedef struct packed {
    logic examine;  // look at the frame under the hand this cycle
    logic claim;    // that frame is taken as the victim
  } sweepCmd_t;
endpackage

// File: rtl/clock_frame_bits.sv
module clock_frame_bits
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CHANCES = 2,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refValid,
  input  logic [IDXW-1:0] refFrame,
  input  logic            refWrite,
  input  logic            wbDone,
  input  logic [IDXW-1:0] wbFrame,
  input  sweepCmd_t       cmd,
  input  logic [IDXW-1:0] hand,
  output logic            evictOk,
  output logic            dirtyNow
);
  localparam int CW = (CHANCES > 1) ? $clog2(CHANCES) : 1;
  localparam logic [CW-1:0] LAST_CHANCE = CW'(CHANCES - 1);

  logic [NUM_FRAMES-1:0] useBits;
  logic [NUM_FRAMES-1:0] modBits;
  logic [CW-1:0]         cntBits [NUM_FRAMES];

  assign evictOk  = !useBits[hand] && (cntBits[hand] == LAST_CHANCE);
  assign dirtyNow = modBits[hand] || (refValid && refWrite && (refFrame == hand));

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : gFrame
    logic refHit;
    logic atHand;
    assign refHit = refValid && (refFrame == IDXW'(g));
    assign atHand = cmd.examine && (hand == IDXW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        useBits[g] <= 1'b0;
        modBits[g] <= 1'b0;
        cntBits[g] <= '0;
      end else begin
        if (refHit)
          useBits[g] <= 1'b1;
        else if (atHand && useBits[g])
          useBits[g] <= 1'b0;

        if (refHit && refWrite)
          modBits[g] <= 1'b1;
        else if (wbDone && (wbFrame == IDXW'(g)))
          modBits[g] <= 1'b0;

        if (refHit)
          cntBits[g] <= '0;
        else if (atHand) begin
          if (useBits[g] || cmd.claim)
            cntBits[g] <= '0;
          else
            cntBits[g] <= cntBits[g] + 1'b1;
        end
      end
    end
  end

  AST_REF_SETS_USE: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> useBits[$past(refFrame)]);  // R2

  AST_WRITE_SETS_MOD: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refWrite) |=> modBits[$past(refFrame)]);  // R3

  AST_WB_CLEARS_MOD: assert property (@(posedge clk) disable iff (!rstN)
    (wbDone && !(refValid && refWrite && refFrame == wbFrame)) |=> !modBits[$past(wbFrame)]);  // R3

  AST_SWEEP_CLEARS_USE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.examine && useBits[hand] && !(refValid && refFrame == hand)) |=> !useBits[$past(hand)]);  // R5

  AST_REF_BEATS_SWEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.examine && refValid && refFrame == hand) |=> useBits[$past(hand)]);  // R10
endmodule

// File: rtl/clock_hand_ctrl.sv
module clock_hand_ctrl
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            faultReq,
  input  logic            evictOk,
  input  logic            dirtyNow,
  output sweepCmd_t       cmd,
  output logic [IDXW-1:0] hand,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] victimFrame,
  output logic            victimDirty
);
  localparam logic [IDXW-1:0] LAST_FRAME = IDXW'(NUM_FRAMES - 1);

  sweepState_t state;
  logic [IDXW-1:0] handNext;

  assign busy        = (state == ST_SWEEP);
  assign cmd.examine = busy;
  assign cmd.claim   = busy && evictOk;
  assign handNext    = (hand == LAST_FRAME) ? '0 : hand + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      hand        <= '0;
      done        <= 1'b0;
      victimFrame <= '0;
      victimDirty <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (faultReq) state <= ST_SWEEP;
        ST_SWEEP: begin
          hand <= handNext;
          if (evictOk) begin
            done        <= 1'b1;
            victimFrame <= hand;
            victimDirty <= dirtyNow;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R6

  AST_DONE_ENDS_SWEEP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));  // R4

  AST_HAND_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(hand));  // R4

  AST_HAND_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> (hand == (($past(hand) == LAST_FRAME) ? '0 : $past(hand) + 1'b1)));  // R5
endmodule

// File: rtl/clock_replacer.sv
module clock_replacer
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CHANCES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] refFrame,
  input  logic                          refWrite,
  input  logic                          wbDone,
  input  logic [$clog2(NUM_FRAMES)-1:0] wbFrame,
  input  logic                          faultReq,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(NUM_FRAMES)-1:0] victimFrame,
  output logic                          victimDirty,
  output logic [$clog2(NUM_FRAMES)-1:0] hand
);
  localparam int IDXW = $clog2(NUM_FRAMES);

  sweepCmd_t cmd;
  logic evictOk;
  logic dirtyNow;

  clock_hand_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .faultReq(faultReq), .evictOk(evictOk),
    .dirtyNow(dirtyNow), .cmd(cmd), .hand(hand), .busy(busy), .done(done),
    .victimFrame(victimFrame), .victimDirty(victimDirty)
  );

  clock_frame_bits #(.NUM_FRAMES(NUM_FRAMES), .CHANCES(CHANCES), .IDXW(IDXW)) uBits (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFrame(refFrame),
    .refWrite(refWrite), .wbDone(wbDone), .wbFrame(wbFrame), .cmd(cmd),
    .hand(hand), .evictOk(evictOk), .dirtyNow(dirtyNow)
  );

  initial assert (NUM_FRAMES >= 2 && CHANCES >= 1);  // R1
endmodule

// File: tb/sim_clock_replacer.sv
module sim_clock_replacer;
  localparam int N = 8;
  localparam int CH = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN;
  logic refValid, refWrite, wbDone, faultReq;
  logic [IW-1:0] refFrame, wbFrame, victimFrame, hand;
  logic busy, done, victimDirty;

  always #10 clk = ~clk;

  clock_replacer #(.NUM_FRAMES(N), .CHANCES(CH)) u0 (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFrame(refFrame),
    .refWrite(refWrite), .wbDone(wbDone), .wbFrame(wbFrame),
    .faultReq(faultReq), .busy(busy), .done(done),
    .victimFrame(victimFrame), .victimDirty(victimDirty), .hand(hand)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit mUse[N];
  bit mMod[N];
  int mCnt[N];
  int mHand;
  bit mBusy, mDone, mDirty;
  int mVic;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, advance the model, compare after the edge.
  task automatic step(bit rv, int rf, bit rw, bit wv, int wf, bit fr);
    refValid = rv; refFrame = IW'(rf); refWrite = rw;
    wbDone = wv; wbFrame = IW'(wf); faultReq = fr;
    mDone = 0;
    if (mBusy) begin
      int h = mHand;
      if (mUse[h]) begin
        mUse[h] = 0; mCnt[h] = 0;
      end else if (mCnt[h] == CH - 1) begin
        mDone = 1; mVic = h;
        mDirty = mMod[h] || (rv && rw && rf == h);
        mCnt[h] = 0; mBusy = 0;
      end else begin
        mCnt[h]++;
      end
      mHand = (h + 1) % N;
    end else if (fr) begin
      mBusy = 1;
    end
    if (wv) mMod[wf] = 0;
    if (rv) begin
      mUse[rf] = 1; mCnt[rf] = 0;
      if (rw) mMod[rf] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    check("R4", "busy", int'(busy), int'(mBusy));
    check("R5", "hand", int'(hand), mHand);
    check("R6", "done", int'(done), int'(mDone));
    if (mDone) begin
      check("R6", "victimFrame", int'(victimFrame), mVic);
      check("R9", "victimDirty", int'(victimDirty), int'(mDirty));
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  // Issue a fault and run idle cycles until the model reports done.
  task automatic sweep(output int cycles);
    step(0, 0, 0, 0, 0, 1);
    cycles = 0;
    do begin
      idle();
      cycles++;
    end while (!mDone && cycles < 100);
  endtask

  task automatic refAll(bit wr);
    for (int f = 0; f < N; f++) step(1, f, wr, 0, 0, 0);
  endtask

  initial begin
    int cyc;
    for (int f = 0; f < N; f++) begin
      mUse[f] = 0; mMod[f] = 0; mCnt[f] = 0;
    end
    mHand = 0; mBusy = 0; mDone = 0; mDirty = 0; mVic = 0;
    rstN = 1'b0; refValid = 0; refWrite = 0; wbDone = 0; faultReq = 0;
    refFrame = '0; wbFrame = '0;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset hand", int'(hand), 0);
    rstN = 1'b1;

    // R1/R8: clear frames each need one skip before eviction
    sweep(cyc);
    check("R8", "first sweep cycles", cyc, N + 1);
    check("R1", "first victim", int'(victimFrame), 0);
    check("R1", "first victim clean", int'(victimDirty), 0);
    check("R6", "hand after victim", int'(hand), 1);

    // R7/R9: every frame written, sweep wraps back to the start frame
    refAll(1);
    sweep(cyc);
    check("R7", "all-used victim", int'(victimFrame), 1);
    check("R7", "all-used cycles", cyc, CH * N + 1);
    check("R9", "written victim dirty", int'(victimDirty), 1);

    // R10: reference the start frame while the hand is on it
    refAll(0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 2, 0, 0, 0, 0);
    cyc = 1;
    while (!mDone && cyc < 100) begin idle(); cyc++; end
    check("R10", "victim after collision", int'(victimFrame), 3);

    // R3: writebacks clear; write beats a same-cycle writeback on frame 5
    for (int f = 0; f < N; f++)
      if (f != 5) step(0, 0, 0, 1, f, 0);
    step(1, 5, 1, 1, 5, 0);
    refAll(0);
    sweep(cyc);
    check("R3", "written-back victim", int'(victimFrame), 4);
    check("R3", "written-back victim clean", int'(victimDirty), 0);
    sweep(cyc);
    check("R3", "write-vs-wb victim", int'(victimFrame), 5);
    check("R3", "write beats writeback", int'(victimDirty), 1);
    check("R6", "immediate victim cycles", cyc, 1);

    // Random mix, model-checked every cycle (R2, R4, R5, R8, R9, R10)
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(99) < 50), int'($urandom_range(N - 1)),
           ($urandom_range(99) < 30), ($urandom_range(99) < 20),
           int'($urandom_range(N - 1)), ($urandom_range(99) < 25));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule